// File: doc/BRIEF.md
# MII to RMII Transmit Bridge

This block sits between a 10/100 Ethernet MAC that transmits over the 4-bit media independent interface and a PHY that expects the reduced 2-bit transmit interface. All of its logic runs on the single 50 MHz reference clock that the PHY also receives. From that clock the block derives the transmit clock it returns to the MAC. It samples the MAC's nibble, enable and error once per transmit-clock period. It then sends the nibble to the PHY as two dibits, least significant pair first.

The line rate is fixed at elaboration by the `SPEED_100` parameter. When the parameter is set, the MAC clock is 25 MHz and each dibit occupies one reference cycle. When it is clear, the MAC clock is 2.5 MHz and each dibit is repeated for `SLOW_REPEAT` reference cycles (10 by default). The block also returns carrier sense and collision to the MAC. It forms them from the PHY's receive carrier indication and the MAC's transmit enable.

Top module: `mii_tx_bridge`

## Requirements
- R1: `mac_tx_clk_o` has a 50 % duty cycle. Its period is 2 reference cycles when `SPEED_100`=1 and 2·`SLOW_REPEAT` reference cycles when `SPEED_100`=0.
- R2: While `rst_ni` is low, `phy_txd_o`=2'b00, `phy_tx_en_o`=0 and `mac_tx_clk_o`=1.
- R3: MAC inputs are sampled on the reference edge one cycle before a rising edge of `mac_tx_clk_o`. The sampled nibble appears on `phy_txd_o` starting at that rising edge.
- R4: Bits [1:0] of the nibble are sent while `mac_tx_clk_o` is high, and bits [3:2] while it is low.
- R5: `phy_txd_o` changes only together with an edge of `mac_tx_clk_o`. Each dibit is therefore held for 1 reference cycle at 100 Mb/s and for `SLOW_REPEAT` cycles at 10 Mb/s.
- R6: `phy_tx_en_o` equals the sampled MAC transmit enable and changes only at rising edges of `mac_tx_clk_o` (nibble boundaries).
- R7: When the sampled enable is 0, `phy_txd_o` is 2'b00 whatever the data and error inputs are.
- R8: When the sampled enable and error are both 1, both dibits of that nibble are 2'b01.
- R9: `mac_crs_o` = `phy_crs_i` OR `mac_tx_en_i`, without a register.
- R10: `mac_col_o` = `phy_crs_i` AND `mac_tx_en_i`, without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_tx_en_i | input | 1 | Transmit enable from the MAC |
| mac_txd_i | input | 4 | Transmit nibble from the MAC |
| mac_tx_er_i | input | 1 | Transmit error from the MAC |
| phy_crs_i | input | 1 | Receive carrier indication from the PHY |
| mac_tx_clk_o | output | 1 | Derived transmit clock to the MAC |
| mac_crs_o | output | 1 | Carrier sense to the MAC |
| mac_col_o | output | 1 | Collision to the MAC |
| phy_txd_o | output | 2 | Transmit dibit to the PHY |
| phy_tx_en_o | output | 1 | Transmit enable to the PHY |

## Verification
Some rules are checked by assertions on every cycle:
- The transmit clock toggles exactly where an independent modulo counter predicts.
- The PHY dibit moves only on a transmit clock edge.
- The PHY enable moves only on a rising edge.
- The dibit is zero whenever the PHY enable is low.
- Collision never appears without carrier sense.

Other behaviour can only be shown by the bench's scenarios at both speeds:
- Which dibit comes first.
- The one-period latency from the MAC to the PHY.
- The error substitution pattern.
- The exact ten-cycle hold at 10 Mb/s.

// File: rtl/mii_txb_pkg.sv
package mii_txb_pkg;
  typedef logic [1:0] dibit_t;
  typedef logic [3:0] nibble_t;

  typedef struct packed {
    logic    er;
    logic    en;
    nibble_t nib;
  } tx_word_t;

  // RMII has no error line: an errored nibble is replaced by this dibit
  localparam dibit_t ERR_DIBIT = 2'b01;

  function automatic int unsigned dibit_cycles(input bit fast, input int unsigned slow_rep);
    return fast ? 1 : slow_rep;
  endfunction
endpackage

// File: rtl/mii_txb_clkgen.sv
module mii_txb_clkgen #(
  parameter int unsigned DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tx_clk_o,
  output logic sample_o,
  output logic load_lo_o,
  output logic load_hi_o
);
  localparam int unsigned PER = 2 * DIV;
  localparam int unsigned CW  = $clog2(PER);

  logic [CW-1:0] pos_q, pos_d;
  logic          clk_q;

  assign pos_d = (pos_q == CW'(PER - 1)) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      clk_q <= 1'b1;
    end else begin
      pos_q <= pos_d;
      clk_q <= (pos_d < CW'(DIV));
    end
  end

  assign tx_clk_o  = clk_q;
  assign sample_o  = (pos_q == CW'(PER - 2)); // one cycle before rising edge
  assign load_lo_o = (pos_q == CW'(PER - 1)); // edge that raises tx clock
  assign load_hi_o = (pos_q == CW'(DIV - 1)); // edge that lowers tx clock
endmodule

// File: rtl/mii_txb_sampler.sv
module mii_txb_sampler
  import mii_txb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sample_i,
  input  tx_word_t mac_word_i,
  output tx_word_t hold_o
);
  tx_word_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (sample_i) hold_q <= mac_word_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/mii_txb_serializer.sv
module mii_txb_serializer
  import mii_txb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tx_clk_i,
  input  logic     load_lo_i,
  input  logic     load_hi_i,
  input  tx_word_t hold_i,
  output dibit_t   txd_o,
  output logic     tx_en_o
);
  dibit_t txd_q;
  logic   en_q;

  function automatic dibit_t pick(input tx_word_t w, input logic upper);
    if (!w.en)     return 2'b00;
    else if (w.er) return ERR_DIBIT;
    else           return upper ? w.nib[3:2] : w.nib[1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q <= '0;
      en_q  <= 1'b0;
    end else if (load_lo_i) begin
      txd_q <= pick(hold_i, 1'b0);
      en_q  <= hold_i.en;
    end else if (load_hi_i) begin
      txd_q <= pick(hold_i, 1'b1);
    end
  end

  assign txd_o   = txd_q;
  assign tx_en_o = en_q;

  AST_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(en_q) |-> $rose(tx_clk_i)) else $error("enable moved off boundary"); // R6
  AST_TXD_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(txd_q) |-> $changed(tx_clk_i)) else $error("dibit moved off edge"); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (txd_q == 2'b00)) else $error("data while idle"); // R7
endmodule

// File: rtl/mii_txb_sense.sv
module mii_txb_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phy_crs_i,
  input  logic mac_tx_en_i,
  output logic mac_crs_o,
  output logic mac_col_o
);
  assign mac_crs_o = phy_crs_i | mac_tx_en_i;
  assign mac_col_o = phy_crs_i & mac_tx_en_i;

  AST_COL_IMPLIES_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_col_o |-> mac_crs_o) else $error("collision without carrier"); // R10
endmodule

// File: rtl/mii_tx_bridge.sv
module mii_tx_bridge
  import mii_txb_pkg::*;
#(
  parameter bit          SPEED_100   = 1'b1,
  parameter int unsigned SLOW_REPEAT = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mac_tx_en_i,
  input  logic [3:0] mac_txd_i,
  input  logic       mac_tx_er_i,
  input  logic       phy_crs_i,
  output logic       mac_tx_clk_o,
  output logic       mac_crs_o,
  output logic       mac_col_o,
  output logic [1:0] phy_txd_o,
  output logic       phy_tx_en_o
);
  localparam int unsigned DIV = dibit_cycles(SPEED_100, SLOW_REPEAT);
  localparam int unsigned KW  = $clog2(DIV + 1);

  logic     tx_clk_w, sample_w, load_lo_w, load_hi_w;
  tx_word_t hold_w;
  tx_word_t mac_word_w;

  assign mac_word_w = '{er: mac_tx_er_i, en: mac_tx_en_i, nib: mac_txd_i};

  mii_txb_clkgen #(.DIV(DIV)) u_clkgen (
    .clk_i, .rst_ni,
    .tx_clk_o (tx_clk_w),
    .sample_o (sample_w),
    .load_lo_o(load_lo_w),
    .load_hi_o(load_hi_w)
  );

  mii_txb_sampler u_sampler (
    .clk_i, .rst_ni,
    .sample_i  (sample_w),
    .mac_word_i(mac_word_w),
    .hold_o    (hold_w)
  );

  mii_txb_serializer u_ser (
    .clk_i, .rst_ni,
    .tx_clk_i (tx_clk_w),
    .load_lo_i(load_lo_w),
    .load_hi_i(load_hi_w),
    .hold_i   (hold_w),
    .txd_o    (phy_txd_o),
    .tx_en_o  (phy_tx_en_o)
  );

  mii_txb_sense u_sense (
    .clk_i, .rst_ni,
    .phy_crs_i,
    .mac_tx_en_i,
    .mac_crs_o,
    .mac_col_o
  );

  assign mac_tx_clk_o = tx_clk_w;

  // independent half-period counter used only to check the clock divider
  logic [KW-1:0] half_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        half_q <= '0;
    else if (half_q == KW'(DIV - 1))    half_q <= '0;
    else                                half_q <= half_q + 1'b1;
  end

  AST_CLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q == KW'(DIV - 1)) |=> $changed(mac_tx_clk_o)) else $error("tx clock late"); // R1
  AST_CLK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q != KW'(DIV - 1)) |=> $stable(mac_tx_clk_o)) else $error("tx clock early"); // R1
endmodule

// File: tb/mii_tx_bridge_tb_top.sv
module mii_tx_bridge_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0, crs = 1'b0;
  logic [3:0] txd = 4'h0;

  logic       f_clk, f_crs, f_col, f_en;
  logic [1:0] f_txd;
  logic       s_clk, s_crs, s_col, s_en;
  logic [1:0] s_txd;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mii_tx_bridge #(.SPEED_100(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mac_tx_en_i(tx_en), .mac_txd_i(txd),
    .mac_tx_er_i(tx_er), .phy_crs_i(crs), .mac_tx_clk_o(f_clk),
    .mac_crs_o(f_crs), .mac_col_o(f_col), .phy_txd_o(f_txd), .phy_tx_en_o(f_en));

  mii_tx_bridge #(.SPEED_100(1'b0), .SLOW_REPEAT(10)) dut_slow_i (
    .clk_i(clk), .rst_ni(rst_n), .mac_tx_en_i(tx_en), .mac_txd_i(txd),
    .mac_tx_er_i(tx_er), .phy_crs_i(crs), .mac_tx_clk_o(s_clk),
    .mac_crs_o(s_crs), .mac_col_o(s_col), .phy_txd_o(s_txd), .phy_tx_en_o(s_en));

  // {er, en, nibble}
  localparam int NV = 8;
  localparam logic [5:0] VEC [NV] = '{
    6'b01_1010, 6'b01_0101, 6'b01_1111, 6'b01_0000,
    6'b11_0110, 6'b10_1001, 6'b00_0011, 6'b01_1100};

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_dibit(input logic [5:0] v, input bit upper);
    if (!v[4])     return 2'b00;
    else if (v[5]) return 2'b01;
    else           return upper ? v[3:2] : v[1:0];
  endfunction

  task automatic drive(input logic [5:0] v);
    tx_er = v[5]; tx_en = v[4]; txd = v[3:0];
  endtask

  task automatic wait_rise(input bit slow);
    if (slow) @(posedge s_clk); else @(posedge f_clk);
  endtask

  task automatic wait_fall(input bit slow);
    if (slow) @(negedge s_clk); else @(negedge f_clk);
  endtask

  function automatic logic [1:0] cur_txd(input bit slow);
    return slow ? s_txd : f_txd;
  endfunction

  task automatic run_table(input bit slow);
    wait_rise(slow); @(negedge clk); drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      wait_rise(slow); @(negedge clk);
      check("R6 phy enable", slow ? s_en : f_en, VEC[i][4]);
      check("R4/R7/R8 low dibit", cur_txd(slow), exp_dibit(VEC[i], 1'b0));
      if (i + 1 < NV) drive(VEC[i+1]); else drive(6'b0);
      wait_fall(slow); @(negedge clk);
      check("R4/R7/R8 high dibit", cur_txd(slow), exp_dibit(VEC[i], 1'b1));
    end
  endtask

  task automatic measure_clk(input bit slow, input int exp_per);
    int n = 1, hi = 1;
    logic prev = 1'b1, c;
    wait_rise(slow); @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      c = slow ? s_clk : f_clk;
      if (c && !prev) break;
      n++; hi += int'(c); prev = c;
    end
    check("R1 tx clock period", n, exp_per);
    check("R1 tx clock high time", hi, exp_per / 2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset txd fast", f_txd, 0);
    check("R2 reset en fast", f_en, 0);
    check("R2 reset clk fast", f_clk, 1);
    check("R2 reset txd slow", s_txd, 0);
    check("R2 reset clk slow", s_clk, 1);
    rst_n = 1'b1;

    measure_clk(1'b0, 2);
    measure_clk(1'b1, 20);

    run_table(1'b0);
    run_table(1'b1);

    // R3: nibble driven right after a rising edge appears at the next rising edge
    wait_rise(1'b0); @(negedge clk); drive(6'b01_1110);
    @(negedge clk);
    check("R3 not yet on phy", f_en, 0);
    wait_rise(1'b0); @(negedge clk);
    check("R3 latency one period", f_txd, 2'b10);
    drive(6'b0);

    // R5: 10 Mb/s dibit hold of ten reference cycles
    begin
      int lo_n = 0, hi_n = 0;
      wait_rise(1'b1); @(negedge clk); drive(6'b01_1011);
      wait_rise(1'b1); @(negedge clk);
      drive(6'b0);
      for (int k = 0; k < 20; k++) begin
        if (k < 10 && s_txd == 2'b11) lo_n++;
        if (k >= 10 && s_txd == 2'b10) hi_n++;
        @(negedge clk);
      end
      check("R5 low dibit held", lo_n, 10);
      check("R5 high dibit held", hi_n, 10);
    end

    // R9 / R10 combinational sense
    for (int m = 0; m < 4; m++) begin
      crs = m[0]; tx_en = m[1];
      #1;
      check("R9 carrier sense", f_crs, m[0] | m[1]);
      check("R10 collision", f_col, m[0] & m[1]);
      check("R10 collision slow", s_col, m[0] & m[1]);
    end
    crs = 1'b0; tx_en = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule